// File: doc/BRIEF.md
# System Timer with One Compare Channel

The block is a memory-mapped system timer. A 64-bit counter runs freely from reset and advances once every third cycle of the input clock, so its rate is one third of the clock frequency. A single compare channel holds a 52-bit match value: a full 32-bit low word and a 20-bit high word. While the channel is enabled and the counter is at or past that value, a sticky status flag is set. The interrupt line follows that flag unless a mask bit holds it low.

Software reaches the block over a plain register bus with an address, a write strobe, write data and combinational read data. The counter can only be read, one 32-bit half at a time. The two halves are not captured together, so software reads the high word, then the low word, then the high word again, and retries if the two high words differ. The interrupt has a single acknowledge: writing the enable bit to zero drops the status flag and the interrupt line. To arm the next event, software disables the channel, writes the high and then the low compare word, and enables it again.

Top module: `sysTimerCmp`

## Requirements
- R1: The counter starts at zero and increases by exactly one on every third rising clock edge. The first increment happens on the third edge after reset is released.
- R2: A read at offset 0x8 returns counter bits 31:0, and a read at offset 0xC returns counter bits 63:32.
- R3: Offset 0x10020 holds the low compare word. Offset 0x10024 keeps only write-data bits 19:0 as the high compare word and reads them back zero-extended. Bits 31:20 of a high-word write have no effect on matching.
- R4: The control word at offset 0x1002C has enable at bit 0 and mask at bit 1, both writable, and the status flag at bit 2, which is read-only. All other bits read zero.
- R5: While enabled, the status flag sets on the clock edge that follows the first cycle in which the counter is greater than or equal to the 52-bit compare value, zero-extended.
- R6: Once set, the status flag stays set while the channel remains enabled, even if the compare value later moves ahead of the counter.
- R7: irqOut is high exactly when the status flag is 1 and mask is 0. Mask does not stop the status flag from setting.
- R8: Writing the control word with bit 0 = 0 clears the status flag and drives irqOut low from the next edge onward.
- R9: While enable is 0, the status flag stays 0 whatever the counter and compare values are.
- R10: A compare write made while the channel is enabled is used for matching from the cycle after the write edge.
- R11: After reset, the counter, both compare words and the control word read zero, and irqOut is low.
- R12: Reads at unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the counter advances at one third of this rate |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 20 | Byte offset of the register being accessed |
| busWe | input | 1 | Write strobe; the write happens at the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Compare interrupt, active high |

## Verification
The prescaler phase and the sticky status flag are the two hidden pieces of state. A wrong phase shows up within three edges: the low counter word read back at consecutive cycles no longer matches the floor of the elapsed edges divided by three. A status flag that sets too early, too late, or that survives an acknowledge shows up on irqOut in the very cycle it goes wrong. For that reason the interrupt is sampled at the exact edge where the counter reaches the compare value and in the cycle right after each control write. Status bit 2 is also read while masked, so a flag that failed to latch under the mask cannot hide behind the low interrupt line.

// File: rtl/sysTimerPkg.sv
`timescale 1ns/1ps
package sysTimerPkg;
  // register offsets; software depends on these exact values
  localparam int unsigned OFS_CNT_LO = 32'h0000_0008;
  localparam int unsigned OFS_CNT_HI = 32'h0000_000C;
  localparam int unsigned OFS_CMP_LO = 32'h0001_0020;
  localparam int unsigned OFS_CMP_HI = 32'h0001_0024;
  localparam int unsigned OFS_CTRL   = 32'h0001_002C;

  // control word bit positions
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_MASK   = 1;
  localparam int unsigned BIT_STATUS = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCmpLo;
    logic wrCmpHi;
  } tmrStrobeT;
endpackage

// File: rtl/tmrDatapath.sv
`timescale 1ns/1ps
module tmrDatapath
  import sysTimerPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 64,
  parameter int CMP_HI_BITS = 20,
  parameter int DIV         = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tmrStrobeT              strobe,
  input  logic [DATA_W-1:0]      wdata,
  output logic [CNT_W-1:0]       cntQ,
  output logic [DATA_W-1:0]      cmpLoQ,
  output logic [CMP_HI_BITS-1:0] cmpHiQ,
  output logic                   hit
);
  localparam int CMP_W = DATA_W + CMP_HI_BITS;

  logic tick;

  // prescaler: one tick every DIV input clocks
  generate
    if (DIV > 1) begin : gPrescale
      localparam int PH_W = $clog2(DIV);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
      logic [PH_W-1:0] phaseQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 phaseQ <= '0;
        else if (phaseQ == PH_LAST) phaseQ <= '0;
        else                       phaseQ <= phaseQ + 1'b1;
      end
      assign tick = (phaseQ == PH_LAST);
    end else begin : gNoPrescale
      assign tick = 1'b1;
    end
  endgenerate

  // free-running counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cntQ <= '0;
    else if (tick) cntQ <= cntQ + 1'b1;
  end

  // compare registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpLoQ <= '0;
      cmpHiQ <= '0;
    end else begin
      if (strobe.wrCmpLo) cmpLoQ <= wdata;
      if (strobe.wrCmpHi) cmpHiQ <= wdata[CMP_HI_BITS-1:0];
    end
  end

  logic [CMP_W-1:0] cmpJoined;
  logic [CNT_W-1:0] cmpFull;
  assign cmpJoined = {cmpHiQ, cmpLoQ};
  assign cmpFull   = CNT_W'(cmpJoined);
  assign hit       = (cntQ >= cmpFull);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cntQ == $past(cntQ)) || (cntQ == $past(cntQ) + 1'b1));

  generate
    if (DIV > 1) begin : gGapChk
      // R1
      cnt_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        (cntQ != $past(cntQ)) |=> $stable(cntQ));
    end
  endgenerate

  // R3
  cmp_hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCmpHi |=> (cmpHiQ == $past(wdata[CMP_HI_BITS-1:0])));
endmodule

// File: rtl/tmrCtrl.sv
`timescale 1ns/1ps
module tmrCtrl
  import sysTimerPkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 64,
  parameter int CMP_HI_BITS = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWe,
  input  logic [1:0]             ctrlBits,
  input  logic [CNT_W-1:0]       cntQ,
  input  logic [DATA_W-1:0]      cmpLoQ,
  input  logic [CMP_HI_BITS-1:0] cmpHiQ,
  input  logic                   hit,
  output tmrStrobeT              strobe,
  output logic [DATA_W-1:0]      busRdata,
  output logic                   irqOut
);
  logic selCntLo, selCntHi, selCmpLo, selCmpHi, selCtrl;
  assign selCntLo = (busAddr == ADDR_W'(OFS_CNT_LO));
  assign selCntHi = (busAddr == ADDR_W'(OFS_CNT_HI));
  assign selCmpLo = (busAddr == ADDR_W'(OFS_CMP_LO));
  assign selCmpHi = (busAddr == ADDR_W'(OFS_CMP_HI));
  assign selCtrl  = (busAddr == ADDR_W'(OFS_CTRL));

  logic ctrlWr, clrWr;
  assign ctrlWr = busWe && selCtrl;
  assign clrWr  = ctrlWr && !ctrlBits[BIT_EN];

  always_comb begin
    strobe         = '0;
    strobe.wrCmpLo = busWe && selCmpLo;
    strobe.wrCmpHi = busWe && selCmpHi;
  end

  logic enQ, maskQ, statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      maskQ <= 1'b0;
    end else if (ctrlWr) begin
      enQ   <= ctrlBits[BIT_EN];
      maskQ <= ctrlBits[BIT_MASK];
    end
  end

  // sticky status: set on match while enabled, cleared by disabling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               statusQ <= 1'b0;
    else if (clrWr || !enQ)  statusQ <= 1'b0;
    else if (hit)            statusQ <= 1'b1;
  end

  assign irqOut = statusQ && !maskQ;

  logic [DATA_W-1:0] ctrlWord;
  always_comb begin
    ctrlWord             = '0;
    ctrlWord[BIT_EN]     = enQ;
    ctrlWord[BIT_MASK]   = maskQ;
    ctrlWord[BIT_STATUS] = statusQ;
  end

  always_comb begin
    busRdata = '0;
    if (selCntLo)      busRdata = cntQ[DATA_W-1:0];
    else if (selCntHi) busRdata = DATA_W'(cntQ >> DATA_W);
    else if (selCmpLo) busRdata = cmpLoQ;
    else if (selCmpHi) busRdata = DATA_W'(cmpHiQ);
    else if (selCtrl)  busRdata = ctrlWord;
  end

  // R5
  status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && hit && !clrWr) |=> statusQ);

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !clrWr) |=> statusQ);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> (!irqOut && !statusQ));

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> !statusQ);
endmodule

// File: rtl/sysTimerCmp.sv
`timescale 1ns/1ps
module sysTimerCmp
  import sysTimerPkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 64,
  parameter int CMP_HI_BITS = 20,
  parameter int DIV         = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  tmrStrobeT              strobe;
  logic [CNT_W-1:0]       cntQ;
  logic [DATA_W-1:0]      cmpLoQ;
  logic [CMP_HI_BITS-1:0] cmpHiQ;
  logic                   hit;

  tmrDatapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CMP_HI_BITS(CMP_HI_BITS), .DIV(DIV)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .cntQ(cntQ), .cmpLoQ(cmpLoQ), .cmpHiQ(cmpHiQ), .hit(hit)
  );

  tmrCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CMP_HI_BITS(CMP_HI_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .ctrlBits(busWdata[1:0]), .cntQ(cntQ), .cmpLoQ(cmpLoQ), .cmpHiQ(cmpHiQ),
    .hit(hit), .strobe(strobe), .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_sysTimerCmp.sv
`timescale 1ns/1ps
module sim_sysTimerCmp;
  localparam logic [19:0] A_CNT_LO = 20'h00008;
  localparam logic [19:0] A_CNT_HI = 20'h0000C;
  localparam logic [19:0] A_CMP_LO = 20'h10020;
  localparam logic [19:0] A_CMP_HI = 20'h10024;
  localparam logic [19:0] A_CTRL   = 20'h1002C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  int edgeCount = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) if (rstN) edgeCount <= edgeCount + 1;

  sysTimerCmp u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } itemT;
  itemT sb[$];

  // monitor: compare queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        itemT it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.isIrq ? {31'b0, irqOut} : busRdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic pushItem(input bit isIrq, input logic [31:0] e, input string tag);
    itemT it;
    it.isIrq = isIrq; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic busWrite(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic expectRead(input logic [19:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busAddr = a;
    pushItem(1'b0, e, tag);
  endtask

  task automatic expectCnt(input string tag);
    @(negedge clk);
    busAddr = A_CNT_LO;
    pushItem(1'b0, 32'(edgeCount / 3), tag);
  endtask

  task automatic expectIrq(input bit e, input string tag);
    @(negedge clk);
    pushItem(1'b1, {31'b0, e}, tag);
  endtask

  task automatic expectIrqNow(input bit e, input string tag);
    pushItem(1'b1, {31'b0, e}, tag);
  endtask

  task automatic finishRun();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: exact prescale phase after reset (edges 1..4 give 0,0,1,1)
    for (int i = 0; i < 4; i++) expectCnt("R1 first increment");

    // R11: reset values
    expectRead(A_CTRL,   32'h0, "R11 ctrl reset");
    expectRead(A_CMP_LO, 32'h0, "R11 cmp lo reset");
    expectRead(A_CMP_HI, 32'h0, "R11 cmp hi reset");
    expectIrq(1'b0, "R11 irq reset");

    // R1 R2: counter tracks edges/3 over several cycles
    for (int i = 0; i < 7; i++) expectCnt("R1 R2 counter low");
    expectRead(A_CNT_HI, 32'h0, "R2 counter high");

    // R12: unmapped offsets
    expectRead(20'h00004, 32'h0, "R12 unmapped 0x4");
    expectRead(20'h10028, 32'h0, "R12 unmapped 0x10028");

    // R3: compare registers
    busWrite(A_CMP_HI, 32'hABCDE123);
    expectRead(A_CMP_HI, 32'h000DE123, "R3 cmp hi keeps 20 bits");
    busWrite(A_CMP_LO, 32'h12345678);
    expectRead(A_CMP_LO, 32'h12345678, "R3 cmp lo readback");
    busWrite(A_CMP_HI, 32'hFFF00000);
    expectRead(A_CMP_HI, 32'h0, "R3 cmp hi upper dropped");

    // R4: mask only, other bits ignored
    busWrite(A_CTRL, 32'hFFFFFFFA);
    expectRead(A_CTRL, 32'h2, "R4 ctrl mask only");

    // R9: disabled, compare in the past -> no status
    busWrite(A_CTRL, 32'h0);
    busWrite(A_CMP_LO, 32'h0);
    repeat (6) @(negedge clk);
    expectRead(A_CTRL, 32'h0, "R9 status stays clear");
    expectIrq(1'b0, "R9 irq low while disabled");

    // R3 R5: effective compare is 0 despite hi upper bits; enable
    busWrite(A_CTRL, 32'h1);
    expectIrqNow(1'b0, "R5 no status on enable edge");
    expectIrq(1'b1, "R3 R5 irq one cycle later");
    expectRead(A_CTRL, 32'h5, "R4 status bit reads back");

    // R8: acknowledge
    busWrite(A_CTRL, 32'h0);
    expectIrqNow(1'b0, "R8 irq drops after ack");
    expectRead(A_CTRL, 32'h0, "R8 status cleared");

    // R5: exact match timing
    c = edgeCount / 3 + 12;
    busWrite(A_CMP_LO, 32'(c));
    busWrite(A_CTRL, 32'h1);
    while (edgeCount < 3 * c) @(negedge clk);
    expectIrqNow(1'b0, "R5 irq low at match cycle");
    expectIrq(1'b1, "R5 irq high after match");

    // R6: move compare ahead, status stays
    busWrite(A_CMP_LO, 32'hFFFFFFF0);
    repeat (3) @(negedge clk);
    expectIrq(1'b1, "R6 status sticky");

    // R7: mask gating
    busWrite(A_CTRL, 32'h3);
    expectIrqNow(1'b0, "R7 masked irq low");
    expectRead(A_CTRL, 32'h7, "R7 status kept under mask");
    busWrite(A_CTRL, 32'h1);
    expectIrqNow(1'b1, "R7 unmask irq high");
    busWrite(A_CTRL, 32'h0);
    expectIrqNow(1'b0, "R8 second ack");

    // R10: compare write while enabled
    busWrite(A_CTRL, 32'h1);
    expectIrqNow(1'b0, "R10 far compare no irq");
    expectIrq(1'b0, "R10 far compare still no irq");
    busWrite(A_CMP_LO, 32'h0);
    expectIrqNow(1'b0, "R10 not before next cycle");
    expectIrq(1'b1, "R10 new compare used");
    busWrite(A_CTRL, 32'h0);

    // R7: status latches while masked from the start
    busWrite(A_CTRL, 32'h3);
    expectIrqNow(1'b0, "R7 masked from enable");
    expectIrq(1'b0, "R7 still masked");
    expectRead(A_CTRL, 32'h7, "R7 status latched masked");
    busWrite(A_CTRL, 32'h1);
    expectIrqNow(1'b1, "R7 release mask");
    busWrite(A_CTRL, 32'h0);
    expectIrqNow(1'b0, "R8 final ack");

    expectCnt("R1 R2 counter late");
    expectRead(A_CNT_HI, 32'h0, "R2 counter high late");

    done = 1'b1;
    finishRun();
  end
endmodule